// File: doc/BRIEF.md
# Up-Counting Event Timer with Posted Writes

This block is a general-purpose event timer driven through a small synchronous register bus. A counter of `WIDTH` bits (32 by default) counts upward while its run bit is set, and signals an overflow event when it steps past the all-ones value. To get an event after N counting cycles, software loads the counter with all-ones minus N. In autoreload mode the counter restarts from a separately held reload value after each overflow, which gives a periodic tick. In one-shot mode the counter wraps to zero and the timer stops itself.

Writes to the run/mode control, the reload value and the counter are posted. Each one passes through a `SYNC_DEPTH`-stage resynchronisation pipe (three stages by default) and is committed only when it leaves the pipe. A readable pending flag shows while any such write is still in flight. This latency also sets the shortest delay that software can program. The interrupt-enable and status registers act at once. The status flag is cleared by writing a one to it. The interrupt output is the status flag gated by the enable.

Register word addresses: 0 control (bit 0 run, bit 1 autoreload), 1 reload value, 2 counter, 3 interrupt enable (bit 0), 4 overflow status (bit 0, write-one-to-clear), 5 write pending (bit 0, read-only). Unused addresses and bits read as zero.

Top module: `evtimer_top`

## Requirements
- R1: After reset the control, reload, counter, enable and status registers all read zero, the pending flag (address 5 bit 0) reads zero and `irq_o` is low.
- R2: A write to address 0, 1 or 2 takes effect on the third rising clock edge after the edge that captures it. The pending flag is high for exactly those three cycles, and the old value stays visible until the commit.
- R3: While the run bit (address 0 bit 0) is set, the counter increases by one on every clock edge, and address 2 returns its live value.
- R4: A counter loaded with all-ones minus N and then started reaches all-ones after N counting edges. It overflows on edge N+1, and the overflow sets the status flag (address 4 bit 0).
- R5: With the autoreload bit (address 0 bit 1) set, each overflow copies the reload value into the counter and counting continues, so overflows repeat every N+1 cycles for a reload value of all-ones minus N.
- R6: With autoreload clear, the overflow leaves the counter at zero and clears the run bit, and the counter then holds at zero.
- R7: A committed write that clears the run bit freezes the counter at its current value.
- R8: Writing 1 to address 4 bit 0 clears the status flag on the capturing edge. Writing 0 there has no effect, and an overflow on the same edge as a clear leaves the flag set.
- R9: `irq_o` is high exactly when both the status flag and the enable bit (address 3 bit 0) are set.
- R10: A write to the reload value alone does not change the counter.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Timer and bus clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| bus_sel_i | input | 1 | Bus access select |
| bus_we_i | input | 1 | Write strobe, qualified by select |
| bus_addr_i | input | ADDR_W | Register word address |
| bus_wdata_i | input | WIDTH | Write data |
| bus_rdata_o | output | WIDTH | Read data for the addressed register, combinational |
| irq_o | output | 1 | Overflow interrupt request |

## Verification
The bench counts edges exactly from each posted write to its commit. A design that commits one edge early or late, or that drops the pending flag too soon, shows the new counter value on the wrong cycle. The one-shot pass is checked one cycle before and one cycle after the overflow. An off-by-one period, or a timer that keeps running after one-shot expiry, shows up as a wrong counter or run bit. Autoreload is checked over two periods, with a write-zero and a write-one to the status flag in between. This catches a flag that clears on any write, or a reload that uses zero instead of the reload value. Stopping is checked by reading the counter several cycles apart: a design that resets the counter or keeps counting fails that check.

// File: rtl/evt_pkg.sv
package evt_pkg;
   // register word addresses
   localparam int unsigned REG_CTRL  = 0;
   localparam int unsigned REG_LOAD  = 1;
   localparam int unsigned REG_COUNT = 2;
   localparam int unsigned REG_IEN   = 3;
   localparam int unsigned REG_STAT  = 4;
   localparam int unsigned REG_PEND  = 5;

   // control field positions
   localparam int unsigned CTRL_RUN_BIT    = 0;
   localparam int unsigned CTRL_RELOAD_BIT = 1;

   // destination of a posted write
   typedef enum logic [1:0] {
      TGT_CTRL  = 2'd0,
      TGT_LOAD  = 2'd1,
      TGT_COUNT = 2'd2
   } post_tgt_e;
endpackage

// File: rtl/evt_post_pipe.sv
module evt_post_pipe
   import evt_pkg::*;
#(
   parameter int unsigned WIDTH = 32,
   parameter int unsigned DEPTH = 3
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             in_vld_i,
   input  post_tgt_e        in_tgt_i,
   input  logic [WIDTH-1:0] in_dat_i,
   output logic             cm_vld_o,
   output post_tgt_e        cm_tgt_o,
   output logic [WIDTH-1:0] cm_dat_o,
   output logic             pend_o
);
   localparam int unsigned LAST = DEPTH - 1;

   logic [DEPTH-1:0] vld_q;
   post_tgt_e        tgt_q [DEPTH];
   logic [WIDTH-1:0] dat_q [DEPTH];

   generate
      if (DEPTH < 1) begin : g_bad_depth
         $error("evt_post_pipe: DEPTH must be at least 1");
      end
      for (genvar g = 0; g < DEPTH; g++) begin : g_stage
         if (g == 0) begin : g_head
            always_ff @(posedge clk_i or negedge rst_ni) begin
               if (!rst_ni) begin
                  vld_q[g] <= 1'b0;
                  tgt_q[g] <= TGT_CTRL;
                  dat_q[g] <= '0;
               end else begin
                  vld_q[g] <= in_vld_i;
                  tgt_q[g] <= in_tgt_i;
                  dat_q[g] <= in_dat_i;
               end
            end
         end else begin : g_body
            always_ff @(posedge clk_i or negedge rst_ni) begin
               if (!rst_ni) begin
                  vld_q[g] <= 1'b0;
                  tgt_q[g] <= TGT_CTRL;
                  dat_q[g] <= '0;
               end else begin
                  vld_q[g] <= vld_q[g-1];
                  tgt_q[g] <= tgt_q[g-1];
                  dat_q[g] <= dat_q[g-1];
               end
            end
         end
      end
   endgenerate

   assign cm_vld_o = vld_q[LAST];
   assign cm_tgt_o = tgt_q[LAST];
   assign cm_dat_o = dat_q[LAST];
   assign pend_o   = |vld_q;

   // R2: the pending flag only drops after a write has left the pipe
   assert_pend_drop_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(pend_o) |-> $past(cm_vld_o));
   // R2: an accepted write always makes the pipe report pending
   assert_pend_rise_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      in_vld_i |=> pend_o);
endmodule

// File: rtl/evt_counter.sv
module evt_counter
   import evt_pkg::*;
#(
   parameter int unsigned WIDTH = 32
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             cm_vld_i,
   input  post_tgt_e        cm_tgt_i,
   input  logic [WIDTH-1:0] cm_dat_i,
   output logic [WIDTH-1:0] cnt_o,
   output logic [WIDTH-1:0] load_o,
   output logic             run_o,
   output logic             reload_o,
   output logic             ovf_o
);
   localparam logic [WIDTH-1:0] ALL_ONES = '1;

   logic [WIDTH-1:0] cnt_q, load_q;
   logic             run_q, reload_q;
   logic             wr_cnt, wr_load, wr_ctrl, wrap;

   assign wr_cnt  = cm_vld_i && (cm_tgt_i == TGT_COUNT);
   assign wr_load = cm_vld_i && (cm_tgt_i == TGT_LOAD);
   assign wr_ctrl = cm_vld_i && (cm_tgt_i == TGT_CTRL);
   assign wrap    = run_q && (cnt_q == ALL_ONES);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         cnt_q <= '0;
      end else if (wr_cnt) begin
         cnt_q <= cm_dat_i;
      end else if (wrap) begin
         cnt_q <= reload_q ? load_q : '0;
      end else if (run_q) begin
         cnt_q <= cnt_q + 1'b1;
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         load_q <= '0;
      end else if (wr_load) begin
         load_q <= cm_dat_i;
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         run_q    <= 1'b0;
         reload_q <= 1'b0;
      end else if (wr_ctrl) begin
         run_q    <= cm_dat_i[CTRL_RUN_BIT];
         reload_q <= cm_dat_i[CTRL_RELOAD_BIT];
      end else if (wrap && !reload_q) begin
         run_q <= 1'b0;
      end
   end

   assign cnt_o    = cnt_q;
   assign load_o   = load_q;
   assign run_o    = run_q;
   assign reload_o = reload_q;
   assign ovf_o    = wrap;

   // R3: counting steps by one
   assert_step_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (run_q && cnt_q != ALL_ONES && !wr_cnt) |=> cnt_q == $past(cnt_q) + 1'b1);
   // R5/R6: the value after a wrap depends on the mode
   assert_wrap_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wrap && !wr_cnt) |=> cnt_q == ($past(reload_q) ? $past(load_q) : '0));
   // R6: one-shot expiry stops the timer
   assert_oneshot_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wrap && !reload_q && !wr_ctrl) |=> !run_q);
   // R7: a stopped counter holds its value
   assert_hold_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!run_q && !wr_cnt) |=> $stable(cnt_q));
   // R10: a reload-value commit leaves a stopped counter alone
   assert_load_only_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_load && !run_q) |=> $stable(cnt_q));
endmodule

// File: rtl/evt_irq.sv
module evt_irq (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic ovf_i,
   input  logic ien_wr_i,
   input  logic stat_wr_i,
   input  logic wbit_i,
   output logic ien_o,
   output logic stat_o,
   output logic irq_o
);
   logic ien_q, stat_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         ien_q <= 1'b0;
      end else if (ien_wr_i) begin
         ien_q <= wbit_i;
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         stat_q <= 1'b0;
      end else if (ovf_i) begin
         stat_q <= 1'b1;
      end else if (stat_wr_i && wbit_i) begin
         stat_q <= 1'b0;
      end
   end

   assign ien_o  = ien_q;
   assign stat_o = stat_q;
   assign irq_o  = stat_q & ien_q;

   // R8: an overflow always leaves the flag set
   assert_set_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ovf_i |=> stat_o);
   // R8: write-one clears, write-zero keeps
   assert_clr_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (stat_wr_i && wbit_i && !ovf_i) |=> !stat_o);
   assert_keep_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (stat_wr_i && !wbit_i && stat_o) |=> stat_o);
endmodule

// File: rtl/evtimer_top.sv
module evtimer_top
   import evt_pkg::*;
#(
   parameter int unsigned WIDTH      = 32,
   parameter int unsigned SYNC_DEPTH = 3,
   parameter int unsigned ADDR_W     = 3
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              bus_sel_i,
   input  logic              bus_we_i,
   input  logic [ADDR_W-1:0] bus_addr_i,
   input  logic [WIDTH-1:0]  bus_wdata_i,
   output logic [WIDTH-1:0]  bus_rdata_o,
   output logic              irq_o
);
   localparam int unsigned NUM_REGS = REG_PEND + 1;

   generate
      if (WIDTH < 8) begin : g_bad_width
         $error("evtimer_top: WIDTH must be at least 8");
      end
      if ((1 << ADDR_W) < NUM_REGS) begin : g_bad_addr
         $error("evtimer_top: ADDR_W too narrow for the register map");
      end
   endgenerate

   logic             wr_en;
   logic             post_vld;
   post_tgt_e        post_tgt;
   logic             cm_vld;
   post_tgt_e        cm_tgt;
   logic [WIDTH-1:0] cm_dat;
   logic             pend;
   logic [WIDTH-1:0] cnt, load;
   logic             run, reload, ovf;
   logic             ien, stat;
   logic             ien_wr, stat_wr;

   assign wr_en   = bus_sel_i && bus_we_i;
   assign ien_wr  = wr_en && (bus_addr_i == ADDR_W'(REG_IEN));
   assign stat_wr = wr_en && (bus_addr_i == ADDR_W'(REG_STAT));

   always_comb begin
      post_vld = 1'b0;
      post_tgt = TGT_CTRL;
      if (wr_en) begin
         if (bus_addr_i == ADDR_W'(REG_CTRL)) begin
            post_vld = 1'b1;
            post_tgt = TGT_CTRL;
         end else if (bus_addr_i == ADDR_W'(REG_LOAD)) begin
            post_vld = 1'b1;
            post_tgt = TGT_LOAD;
         end else if (bus_addr_i == ADDR_W'(REG_COUNT)) begin
            post_vld = 1'b1;
            post_tgt = TGT_COUNT;
         end
      end
   end

   evt_post_pipe #(.WIDTH(WIDTH), .DEPTH(SYNC_DEPTH)) u_pipe (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .in_vld_i (post_vld),
      .in_tgt_i (post_tgt),
      .in_dat_i (bus_wdata_i),
      .cm_vld_o (cm_vld),
      .cm_tgt_o (cm_tgt),
      .cm_dat_o (cm_dat),
      .pend_o   (pend)
   );

   evt_counter #(.WIDTH(WIDTH)) u_cnt (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .cm_vld_i (cm_vld),
      .cm_tgt_i (cm_tgt),
      .cm_dat_i (cm_dat),
      .cnt_o    (cnt),
      .load_o   (load),
      .run_o    (run),
      .reload_o (reload),
      .ovf_o    (ovf)
   );

   evt_irq u_irq (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .ovf_i     (ovf),
      .ien_wr_i  (ien_wr),
      .stat_wr_i (stat_wr),
      .wbit_i    (bus_wdata_i[0]),
      .ien_o     (ien),
      .stat_o    (stat),
      .irq_o     (irq_o)
   );

   always_comb begin
      bus_rdata_o = '0;
      if (bus_addr_i == ADDR_W'(REG_CTRL)) begin
         bus_rdata_o[CTRL_RUN_BIT]    = run;
         bus_rdata_o[CTRL_RELOAD_BIT] = reload;
      end else if (bus_addr_i == ADDR_W'(REG_LOAD)) begin
         bus_rdata_o = load;
      end else if (bus_addr_i == ADDR_W'(REG_COUNT)) begin
         bus_rdata_o = cnt;
      end else if (bus_addr_i == ADDR_W'(REG_IEN)) begin
         bus_rdata_o[0] = ien;
      end else if (bus_addr_i == ADDR_W'(REG_STAT)) begin
         bus_rdata_o[0] = stat;
      end else if (bus_addr_i == ADDR_W'(REG_PEND)) begin
         bus_rdata_o[0] = pend;
      end
   end

   // R9: the request never fires while masked or without a pending event
   assert_irq_gate_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      irq_o |-> (ien && stat));
endmodule

// File: tb/evtimer_top_tb_top.sv
`timescale 1ns/1ps
module evtimer_top_tb_top;
   localparam logic [31:0] MAX = 32'hFFFF_FFFF;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        sel = 1'b0;
   logic        we = 1'b0;
   logic [2:0]  addr = '0;
   logic [31:0] wdata = '0;
   logic [31:0] rdata;
   logic        irq;
   int          checks = 0;
   int          errors = 0;
   bit          done = 1'b0;

   always #2 clk = ~clk;

   evtimer_top dut_i (
      .clk_i       (clk),
      .rst_ni      (rst_n),
      .bus_sel_i   (sel),
      .bus_we_i    (we),
      .bus_addr_i  (addr),
      .bus_wdata_i (wdata),
      .bus_rdata_o (rdata),
      .irq_o       (irq)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   // called at a negedge; the write is captured by the next rising edge
   task automatic wr(input int a, input logic [31:0] d);
      sel = 1'b1; we = 1'b1; addr = 3'(a); wdata = d;
      @(negedge clk);
      sel = 1'b0; we = 1'b0; wdata = '0;
   endtask

   task automatic rd(input int a, output logic [31:0] v);
      addr = 3'(a);
      #0.5;
      v = rdata;
   endtask

   task automatic do_reset;
      rst_n = 1'b0;
      sel = 1'b0; we = 1'b0; wdata = '0;
      tick(3);
      rst_n = 1'b1;
      tick(1);
   endtask

   task automatic t_reset;
      logic [31:0] v;
      do_reset();
      for (int a = 0; a < 6; a++) begin
         rd(a, v);
         chk($sformatf("R1 reset reg %0d", a), v, 32'h0);
      end
      chk("R1 irq at reset", {31'b0, irq}, 32'h0);
   endtask

   task automatic t_posted;
      logic [31:0] v;
      do_reset();
      wr(2, 32'h100);               // captured P0, returns n0
      rd(5, v); chk("R2 pending after write", v, 32'h1);
      rd(2, v); chk("R2 old counter before commit", v, 32'h0);
      tick(2);                      // n2
      rd(5, v); chk("R2 pending in last cycle", v, 32'h1);
      rd(2, v); chk("R2 counter not yet committed", v, 32'h0);
      tick(1);                      // n3
      rd(5, v); chk("R2 pending cleared", v, 32'h0);
      rd(2, v); chk("R2 counter committed", v, 32'h100);
      wr(1, 32'h55);
      tick(4);
      rd(2, v); chk("R10 reload write leaves counter", v, 32'h100);
      rd(1, v); chk("R10 reload value stored", v, 32'h55);
   endtask

   task automatic t_oneshot;
      logic [31:0] v;
      do_reset();
      wr(3, 32'h1);
      wr(2, MAX - 32'd4);           // P0
      wr(0, 32'h1);                 // P1, returns n1
      tick(5);                      // n6
      rd(2, v); chk("R3 counting one per cycle", v, MAX - 32'd2);
      tick(2);                      // n8
      rd(2, v); chk("R4 reaches all-ones after N steps", v, MAX);
      rd(4, v); chk("R4 no overflow before step N+1", v, 32'h0);
      chk("R9 irq low before overflow", {31'b0, irq}, 32'h0);
      tick(1);                      // n9
      rd(4, v); chk("R4 status set on overflow", v, 32'h1);
      chk("R9 irq with enable", {31'b0, irq}, 32'h1);
      rd(2, v); chk("R6 one-shot wraps to zero", v, 32'h0);
      rd(0, v); chk("R6 run bit cleared", v, 32'h0);
      tick(2);
      rd(2, v); chk("R6 counter holds after expiry", v, 32'h0);
   endtask

   task automatic t_periodic;
      logic [31:0] v;
      do_reset();
      wr(1, MAX - 32'd2);           // P0
      wr(2, MAX - 32'd2);           // P1
      wr(0, 32'h3);                 // P2, returns n2
      tick(6);                      // n8
      rd(2, v); chk("R5 reloaded after overflow", v, MAX - 32'd2);
      rd(4, v); chk("R5 first overflow flagged", v, 32'h1);
      chk("R9 irq masked", {31'b0, irq}, 32'h0);
      rd(0, v); chk("R5 still running with autoreload", v, 32'h3);
      wr(4, 32'h0);                 // P9, returns n9
      rd(4, v); chk("R8 write zero keeps flag", v, 32'h1);
      wr(4, 32'h1);                 // P10, returns n10
      rd(4, v); chk("R8 write one clears flag", v, 32'h0);
      tick(1);                      // n11
      rd(4, v); chk("R5 second overflow after N+1", v, 32'h1);
      rd(2, v); chk("R5 second reload", v, MAX - 32'd2);
   endtask

   task automatic t_clash;
      logic [31:0] v;
      do_reset();
      wr(2, MAX - 32'd1);           // P0
      wr(0, 32'h1);                 // P1, returns n1
      // counting P5: MAX, overflow at P6
      tick(4);                      // n5
      wr(4, 32'h1);                 // captured P6, same edge as overflow
      rd(4, v); chk("R8 overflow wins over clear", v, 32'h1);
   endtask

   task automatic t_stop;
      logic [31:0] v;
      do_reset();
      wr(2, 32'h10);                // P0
      wr(0, 32'h1);                 // P1, returns n1
      tick(9);                      // n10
      rd(2, v); chk("R3 running count", v, 32'h16);
      wr(0, 32'h0);                 // P11, commit P14
      tick(3);                      // n14
      rd(2, v); chk("R7 frozen value", v, 32'h1A);
      tick(5);
      rd(2, v); chk("R7 counter unchanged while stopped", v, 32'h1A);
      rd(0, v); chk("R7 run bit clear", v, 32'h0);
   endtask

   initial begin
      t_reset();
      t_posted();
      t_oneshot();
      t_periodic();
      t_clash();
      t_stop();
      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule